// File: doc/BRIEF.md
# Chunked File Byte-Read Engine

This engine pulls a requested number of bytes out of a file that an external storage controller already holds open. A one-cycle start pulse together with a 16-bit byte count launches the transfer. The engine then runs a fixed loop over a byte-wide command link and a byte-wide reply link:

- It issues a read request that carries the count.
- It fetches the status byte.
- While the status says more data is waiting, it fetches a length-prefixed block and passes the block's bytes on.
- It asks the controller to carry on, then fetches the status again.

The controller's status codes alone decide when the loop stops. A success code ends the transfer cleanly. Any code the engine does not expect ends it with an error flag and keeps that code.

Every frame sent to the controller begins with two synchronisation bytes, 0x57 then 0xAB, followed by an opcode and, for the read request only, two parameter bytes. There are three streams, each with valid/ready handshakes:

- **Command stream (out to the framer).** A byte is taken on a cycle where both valid and ready are high. While ready is low, the engine keeps valid and the byte unchanged.
- **Reply stream (in from the controller).** The engine raises ready only when it expects a status or block byte.
- **File-data stream (out to the consumer).** This path is a direct pass-through from the reply stream. If the consumer holds its ready low, the engine holds back the reply stream, so the controller's byte waits in place.

Top module: `file_byte_reader`

## Requirements
- R1: An accepted start pulse emits the frame 0x57, 0xAB, 0x3A, then the requested count low byte, then the high byte.
- R2: After the read frame and after every continue frame, the engine emits the status frame 0x57, 0xAB, 0x22, then accepts exactly one reply byte as the status. While any command byte is pending it never raises reply ready.
- R3: Status 0x1D triggers the fetch frame 0x57, 0xAB, 0x27. The next reply byte is a length L (0 to 255), and the following L reply bytes appear in order on the file-data output. With L = 0, no data byte is output.
- R4: Once a block's last byte has been delivered (or at once when L = 0), the engine emits the continue frame 0x57, 0xAB, 0x3B and returns to R2.
- R5: Status 0x14 sets done high with err low, and no further command byte is emitted.
- R6: Any other status sets done and err high and presents that status value on err_code.
- R7: total_count equals the number of file bytes delivered since the last accepted start. It changes by exactly one per output handshake.
- R8: While out_valid is high and out_ready is low, out_data and out_valid hold and the reply byte is not consumed.
- R9: While tx_valid is high and tx_ready is low, tx_data and tx_valid hold on the next cycle.
- R10: After reset, tx_valid, rx_ready, out_valid, done, err and total_count are all zero.
- R11: A start pulse that arrives while a transfer runs is ignored: the frames, the data and the final count are unchanged.
- R12: An accepted start clears done, err and err_code on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| req_count | input | 16 | Number of bytes to request |
| tx_data | output | 8 | Command byte to the framer |
| tx_valid | output | 1 | Command byte valid |
| tx_ready | input | 1 | Framer accepts the command byte |
| rx_data | input | 8 | Reply byte from the controller |
| rx_valid | input | 1 | Reply byte valid |
| rx_ready | output | 1 | Engine accepts the reply byte |
| out_data | output | 8 | File data byte |
| out_valid | output | 1 | File data byte valid |
| out_ready | input | 1 | Consumer accepts the file byte |
| done | output | 1 | Transfer finished (sticky until next start) |
| err | output | 1 | Transfer ended on an unexpected status |
| err_code | output | 8 | Status value that caused the error |
| total_count | output | CNT_W | File bytes delivered since start |

## Verification
A loop state that is wrong shows up within one frame, because each phase has its own opcode on the command stream. Examples are a missing status fetch, a continue sent before a block has drained, or a fetch sent on the wrong status. A block counter that is off by one shows up at the end of a block: either a length byte is passed through as data, or the continue frame arrives while a data byte is still pending, and both change the data and the final count. A wrong status decision shows up on done, err and err_code within three cycles of the status byte.

// File: rtl/frb_pkg.sv
package frb_pkg;
  localparam int BYTE_W      = 8;
  localparam int REQ_W       = 16;
  localparam int PARAM_BYTES = REQ_W / BYTE_W;
  localparam int FRAME_MAX   = 3 + PARAM_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_STATUS,
    ST_FETCH,
    ST_DRAIN,
    ST_RESUME
  } loop_state_e;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_LEN,
    PH_DATA
  } blk_phase_e;
endpackage

// File: rtl/frb_cmd_tx.sv
module frb_cmd_tx
  import frb_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SYNC_A = 8'h57,
  parameter logic [BYTE_W-1:0] SYNC_B = 8'hAB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] op,
  input  logic              with_param,
  input  logic [REQ_W-1:0]  param,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              sent
);
  localparam int IDX_W = $clog2(FRAME_MAX);

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last;
  logic [BYTE_W-1:0] op_q;
  logic              wp_q;
  logic [REQ_W-1:0]  param_q;
  logic [BYTE_W-1:0] frame [FRAME_MAX];

  assign frame[0] = SYNC_A;
  assign frame[1] = SYNC_B;
  assign frame[2] = op_q;

  for (genvar g = 0; g < PARAM_BYTES; g++) begin : g_param
    assign frame[3+g] = param_q[g*BYTE_W +: BYTE_W];
  end

  assign last     = wp_q ? IDX_W'(FRAME_MAX - 1) : IDX_W'(2);
  assign tx_valid = active;
  assign tx_data  = frame[idx];
  assign sent     = active && tx_ready && (idx == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      op_q    <= '0;
      wp_q    <= 1'b0;
      param_q <= '0;
    end else if (go) begin
      active  <= 1'b1;
      idx     <= '0;
      op_q    <= op;
      wp_q    <= with_param;
      param_q <= param;
    end else if (active && tx_ready) begin
      if (idx == last) active <= 1'b0;
      else             idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/frb_block_rx.sv
module frb_block_rx
  import frb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              beat,
  output logic              fin
);
  blk_phase_e        phase;
  logic [BYTE_W-1:0] remain;

  assign out_valid = (phase == PH_DATA) && rx_valid;
  assign out_data  = rx_data;
  assign rx_ready  = (phase == PH_LEN) || ((phase == PH_DATA) && out_ready);
  assign beat      = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_OFF;
      remain <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        phase <= PH_LEN;
      end else begin
        case (phase)
          PH_LEN: if (rx_valid) begin
            remain <= rx_data;
            if (rx_data == '0) begin
              phase <= PH_OFF;
              fin   <= 1'b1;
            end else begin
              phase <= PH_DATA;
            end
          end
          PH_DATA: if (beat) begin
            remain <= remain - 1'b1;
            if (remain == BYTE_W'(1)) begin
              phase <= PH_OFF;
              fin   <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/frb_ctrl.sv
module frb_ctrl
  import frb_pkg::*;
#(
  parameter int                CNT_W     = 16,
  parameter logic [BYTE_W-1:0] OP_READ   = 8'h3A,
  parameter logic [BYTE_W-1:0] OP_RESUME = 8'h3B,
  parameter logic [BYTE_W-1:0] OP_FETCH  = 8'h27,
  parameter logic [BYTE_W-1:0] OP_STATUS = 8'h22,
  parameter logic [BYTE_W-1:0] CODE_OK   = 8'h14,
  parameter logic [BYTE_W-1:0] CODE_MORE = 8'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REQ_W-1:0]  req_count,
  input  logic              tx_sent,
  input  logic              blk_fin,
  input  logic              beat,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              stat_ready,
  output logic              tx_go,
  output logic [BYTE_W-1:0] tx_op,
  output logic              tx_with_param,
  output logic [REQ_W-1:0]  tx_param,
  output logic              blk_go,
  output logic              done,
  output logic              err,
  output logic [BYTE_W-1:0] err_code,
  output logic [CNT_W-1:0]  total
);
  loop_state_e state;
  logic        sent_seen;

  assign stat_ready = (state == ST_STATUS) && sent_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      sent_seen     <= 1'b0;
      tx_go         <= 1'b0;
      tx_op         <= '0;
      tx_with_param <= 1'b0;
      tx_param      <= '0;
      blk_go        <= 1'b0;
      done          <= 1'b0;
      err           <= 1'b0;
      err_code      <= '0;
    end else begin
      tx_go  <= 1'b0;
      blk_go <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          tx_param      <= req_count;
          done          <= 1'b0;
          err           <= 1'b0;
          err_code      <= '0;
          tx_go         <= 1'b1;
          tx_op         <= OP_READ;
          tx_with_param <= 1'b1;
          state         <= ST_REQ;
        end
        ST_REQ, ST_RESUME: if (tx_sent) begin
          tx_go         <= 1'b1;
          tx_op         <= OP_STATUS;
          tx_with_param <= 1'b0;
          sent_seen     <= 1'b0;
          state         <= ST_STATUS;
        end
        ST_STATUS: begin
          if (tx_sent) sent_seen <= 1'b1;
          if (stat_ready && rx_valid) begin
            if (rx_data == CODE_MORE) begin
              tx_go         <= 1'b1;
              tx_op         <= OP_FETCH;
              tx_with_param <= 1'b0;
              state         <= ST_FETCH;
            end else if (rx_data == CODE_OK) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              done     <= 1'b1;
              err      <= 1'b1;
              err_code <= rx_data;
              state    <= ST_IDLE;
            end
          end
        end
        ST_FETCH: if (tx_sent) begin
          blk_go <= 1'b1;
          state  <= ST_DRAIN;
        end
        ST_DRAIN: if (blk_fin) begin
          tx_go         <= 1'b1;
          tx_op         <= OP_RESUME;
          tx_with_param <= 1'b0;
          state         <= ST_RESUME;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        total <= '0;
    else if (state == ST_IDLE && start) total <= '0;
    else if (beat)                     total <= total + 1'b1;
  end
endmodule

// File: rtl/file_byte_reader.sv
module file_byte_reader
  import frb_pkg::*;
#(
  parameter int                CNT_W     = 16,
  parameter logic [BYTE_W-1:0] SYNC_A    = 8'h57,
  parameter logic [BYTE_W-1:0] SYNC_B    = 8'hAB,
  parameter logic [BYTE_W-1:0] OP_READ   = 8'h3A,
  parameter logic [BYTE_W-1:0] OP_RESUME = 8'h3B,
  parameter logic [BYTE_W-1:0] OP_FETCH  = 8'h27,
  parameter logic [BYTE_W-1:0] OP_STATUS = 8'h22,
  parameter logic [BYTE_W-1:0] CODE_OK   = 8'h14,
  parameter logic [BYTE_W-1:0] CODE_MORE = 8'h1D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [REQ_W-1:0]  req_count,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              done,
  output logic              err,
  output logic [BYTE_W-1:0] err_code,
  output logic [CNT_W-1:0]  total_count
);
  logic              tx_go, tx_with_param, tx_sent;
  logic [BYTE_W-1:0] tx_op;
  logic [REQ_W-1:0]  tx_param;
  logic              blk_go, blk_fin, blk_ready, beat, stat_ready;

  frb_ctrl #(
    .CNT_W(CNT_W), .OP_READ(OP_READ), .OP_RESUME(OP_RESUME),
    .OP_FETCH(OP_FETCH), .OP_STATUS(OP_STATUS),
    .CODE_OK(CODE_OK), .CODE_MORE(CODE_MORE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .req_count(req_count),
    .tx_sent(tx_sent), .blk_fin(blk_fin), .beat(beat),
    .rx_data(rx_data), .rx_valid(rx_valid), .stat_ready(stat_ready),
    .tx_go(tx_go), .tx_op(tx_op), .tx_with_param(tx_with_param),
    .tx_param(tx_param), .blk_go(blk_go), .done(done), .err(err),
    .err_code(err_code), .total(total_count)
  );

  frb_cmd_tx #(.SYNC_A(SYNC_A), .SYNC_B(SYNC_B)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(tx_go), .op(tx_op),
    .with_param(tx_with_param), .param(tx_param),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sent(tx_sent)
  );

  frb_block_rx u_blk (
    .clk(clk), .rst_n(rst_n), .go(blk_go),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(blk_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .beat(beat), .fin(blk_fin)
  );

  assign rx_ready = stat_ready || blk_ready;
endmodule

// File: rtl/file_byte_reader_chk.sv
module file_byte_reader_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [7:0]       tx_data,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             done,
  input logic             err,
  input logic [CNT_W-1:0] total_count
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R9

  AST_NO_TALK_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready)); // R2

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid && !rx_ready && !out_valid); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> total_count == $past(total_count) + 1'b1); // R7

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready) && !start |=> $stable(total_count)); // R7
endmodule

bind file_byte_reader file_byte_reader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_ready(rx_ready),
  .out_valid(out_valid), .out_ready(out_ready), .done(done), .err(err),
  .total_count(total_count)
);

// File: tb/file_byte_reader_test.sv
module file_byte_reader_test;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] req_count = '0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        done, err;
  logic [7:0]  err_code;
  logic [15:0] total_count;

  int n_chk = 0;
  int n_fail = 0;
  int mode = 0;
  int cyc = 0;

  logic [7:0] tx_log [0:4095];
  int tx_n = 0, tx_rd = 0;
  logic [7:0] out_log [0:4095];
  int out_n = 0;

  logic       tx_pend = 1'b0;
  logic [7:0] tx_hold = '0;
  logic       out_pend = 1'b0;
  logic [7:0] out_hold = '0;

  always #(CLK_PER/2) clk = ~clk;

  file_byte_reader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_count(req_count),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .err(err), .err_code(err_code), .total_count(total_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Ready patterns for both outgoing streams
  always @(negedge clk) begin
    cyc++;
    case (mode)
      0: begin out_ready = 1'b1;          tx_ready = 1'b1;          end
      1: begin out_ready = cyc[0];        tx_ready = ~cyc[0];       end
      default: begin out_ready = (cyc % 3 == 0); tx_ready = (cyc % 3 != 1); end
    endcase
  end

  // Stream monitors, sampled after inputs settle, before the next edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (tx_pend) chk(tx_valid && tx_data == tx_hold, "R9", int'(tx_data), int'(tx_hold));
      tx_pend = tx_valid && !tx_ready;
      tx_hold = tx_data;
      if (tx_valid && tx_ready) begin tx_log[tx_n] = tx_data; tx_n++; end
      if (out_pend) chk(out_valid && out_data == out_hold, "R8", int'(out_data), int'(out_hold));
      out_pend = out_valid && !out_ready;
      out_hold = out_data;
      if (out_valid && out_ready) begin out_log[out_n] = out_data; out_n++; end
    end
  end

  function automatic logic [7:0] dbyte(input int p, input int i);
    return 8'((p * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic expect_frame(input logic [7:0] op, input bit wp, input logic [15:0] prm,
                              input string req);
    int k;
    k = wp ? 5 : 3;
    while (tx_n < tx_rd + k) @(negedge clk);
    chk(tx_log[tx_rd] == 8'h57, req, int'(tx_log[tx_rd]), 'h57);
    chk(tx_log[tx_rd+1] == 8'hAB, req, int'(tx_log[tx_rd+1]), 'hAB);
    chk(tx_log[tx_rd+2] == op, req, int'(tx_log[tx_rd+2]), int'(op));
    if (wp) begin
      chk(tx_log[tx_rd+3] == prm[7:0], req, int'(tx_log[tx_rd+3]), int'(prm[7:0]));
      chk(tx_log[tx_rd+4] == prm[15:8], req, int'(tx_log[tx_rd+4]), int'(prm[15:8]));
    end
    tx_rd += k;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    #1;
    while (!rx_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
  endtask

  task automatic run_case(input logic [15:0] req, input int n, input int lens[4],
                          input logic [7:0] fin_st, input int md, input bit poke);
    int base, sum, pos;
    mode = md;
    base = out_n;
    sum = 0;
    @(negedge clk);
    start = 1'b1;
    req_count = req;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(!done && !err && err_code == 8'h00, "R12", int'({done, err}), 0);
    expect_frame(8'h3A, 1'b1, req, "R1");
    if (poke) begin
      @(negedge clk);
      start = 1'b1;
      req_count = 16'hBEEF;
      @(negedge clk);
      start = 1'b0;
    end
    for (int p = 0; p < n; p++) begin
      expect_frame(8'h22, 1'b0, 16'h0, "R2");
      send_rx(8'h1D);
      expect_frame(8'h27, 1'b0, 16'h0, "R3");
      send_rx(8'(lens[p]));
      for (int i = 0; i < lens[p]; i++) send_rx(dbyte(p, i));
      expect_frame(8'h3B, 1'b0, 16'h0, "R4");
      sum += lens[p];
    end
    expect_frame(8'h22, 1'b0, 16'h0, "R2");
    send_rx(fin_st);
    repeat (3) @(negedge clk);
    #2;
    chk(done == 1'b1, fin_st == 8'h14 ? "R5" : "R6", int'(done), 1);
    if (fin_st == 8'h14) begin
      chk(err == 1'b0, "R5", int'(err), 0);
    end else begin
      chk(err == 1'b1, "R6", int'(err), 1);
      chk(err_code == fin_st, "R6", int'(err_code), int'(fin_st));
    end
    chk(tx_n == tx_rd, "R5", tx_n, tx_rd);
    chk(int'(total_count) == sum, poke ? "R11" : "R7", int'(total_count), sum);
    chk(out_n - base == sum, "R3", out_n - base, sum);
    pos = base;
    for (int p = 0; p < n; p++) begin
      for (int i = 0; i < lens[p]; i++) begin
        chk(out_log[pos] == dbyte(p, i), "R3", int'(out_log[pos]), int'(dbyte(p, i)));
        pos++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!tx_valid && !rx_ready && !out_valid, "R10", int'({tx_valid, rx_ready, out_valid}), 0);
    chk(!done && !err && total_count == 16'h0, "R10", int'(total_count), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!tx_valid && !rx_ready && !done, "R10", int'({tx_valid, rx_ready, done}), 0);

    run_case(16'h0102, 0, '{0, 0, 0, 0}, 8'h14, 0, 1'b0);
    run_case(16'h1234, 1, '{5, 0, 0, 0}, 8'h14, 1, 1'b0);
    run_case(16'h00FF, 2, '{0, 3, 0, 0}, 8'h14, 2, 1'b0);
    run_case(16'h0300, 2, '{255, 1, 0, 0}, 8'h14, 1, 1'b0);
    run_case(16'hA55A, 1, '{2, 0, 0, 0}, 8'h42, 0, 1'b1);
    run_case(16'h000C, 3, '{4, 4, 4, 0}, 8'h14, 2, 1'b0);
    run_case(16'h0010, 1, '{6, 0, 0, 0}, 8'h80, 2, 1'b0);
    run_case(16'h0020, 4, '{1, 0, 7, 2}, 8'h14, 1, 1'b1);
    for (int L = 0; L <= 8; L++) begin
      for (int m = 0; m < 3; m++) begin
        run_case(16'(L * 3 + 1), 1, '{L, 0, 0, 0}, 8'h14, m, 1'b0);
      end
    end
    finish_run();
  end
endmodule